// File: doc/BRIEF.md
# Plane scaling descriptor generator

The block turns one plane's source and destination geometry into the scaling part of a plane descriptor. Each axis gets its own mode: destination larger than source means polyphase magnification, smaller means trapezoidal decimation, and equal means no scaling. From the pair of modes it derives a control-word fragment, the line-buffer size the plane needs, and a run of 32-bit words that carry fixed-point scale factors, trapezoid reciprocals, context words and filter-kernel pointers.

Source width and height arrive in 16.16 fixed point, together with the fractional parts of the source x and y start. Destination sizes are integers. A single sequential divider computes every quotient in turn. The words then leave on a valid/ready stream. A request that cannot be honoured is rejected with a one-cycle error pulse, and no words are emitted for it.

Top module: `plane_scale_gen`

## Requirements
- R1: Per axis (horizontal uses the widths, vertical the heights), the integer source size is compared with the destination size. Destination > source selects PPF, destination < source selects TPZ, and equal selects NONE.
- R2: `ctl_o` bit 4 is 1 only when both axes are NONE. A 3-bit code sits in both bits 7:5 and bits 10:8, and all other bits are 0. The code for each horizontal/vertical pair is: PPF/PPF=0, TPZ/PPF=1, PPF/TPZ=2, TPZ/TPZ=3, PPF/NONE=4, NONE/PPF=5, NONE/TPZ=6, TPZ/NONE=7, NONE/NONE=0.
- R3: An axis scale is floor(source_int*65536/destination). A PPF word is bit 30 set, scale bits 16:0 in word bits 24:8, and zeros elsewhere (phase 0). The first TPZ word is scale bits 20:0 in word bits 28:8, and zeros elsewhere.
- R4: The second TPZ word holds floor(0xFFFFFFFF/scale) in bits 15:0, and all other bits are 0.
- R5: For a non-unity request, the word order is fixed, and each group appears only when its condition holds:
  - the scaled-size word, with destination width in bits 11:0 and destination height in bits 27:16;
  - the line-buffer base, if vertical is not NONE;
  - the horizontal PPF word, if horizontal is PPF;
  - the vertical PPF word then 0xC0C0C0C0, if vertical is PPF;
  - the two horizontal TPZ words, if horizontal is TPZ;
  - the two vertical TPZ words then 0xC0C0C0C0, if vertical is TPZ;
  - four words carrying the kernel offset in bits 13:0, if either axis is PPF.
- R6: `lbuf_size_o` is 0 for unity. Otherwise it is max(source width, destination width) times 8 when vertical is TPZ, or times 16 otherwise, rounded up to a multiple of 32.
- R7: A request whose source width, height, x fraction or y fraction has any nonzero fractional bit is rejected.
- R8: A cursor request with a non-unity mode pair is rejected. A cursor request with a unity mode pair is accepted.
- R9: A destination width or height of zero is rejected.
- R10: A rejection raises `err_o` for the cycle after acceptance, emits no words and leaves `req_ready_o` high. `req_ready_o` is high only while idle. A unity request emits no words.
- R11: `done_o` pulses for one cycle after the last word of an accepted request, or right after acceptance for a unity request.
- R12: While `word_valid_o` is high and `word_ready_i` is low, the word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Generator idle, request taken |
| src_w_i | input | 32 | Source width, 16.16 |
| src_h_i | input | 32 | Source height, 16.16 |
| src_x_frac_i | input | 16 | Fractional part of source x |
| src_y_frac_i | input | 16 | Fractional part of source y |
| dst_w_i | input | 12 | Destination width |
| dst_h_i | input | 12 | Destination height |
| cursor_i | input | 1 | Request is for a cursor plane |
| lbuf_base_i | input | 32 | Line-buffer base address |
| kern_off_i | input | 14 | Filter-kernel offset |
| err_o | output | 1 | Request rejected |
| ctl_o | output | 32 | Control-word scaling fragment |
| lbuf_size_o | output | 32 | Line-buffer size |
| word_valid_o | output | 1 | Descriptor word valid |
| word_ready_i | input | 1 | Descriptor word accepted |
| word_data_o | output | 32 | Descriptor word |
| done_o | output | 1 | Request completed |

## Verification
`err_o`, `ctl_o` and `lbuf_size_o` are registered on the accepting edge. The bench therefore reads them at the falling edge straight after the request is taken. The first word follows only after one divider pass per quotient needed (up to four), so its cycle depends on the mode pair. The bench does not predict that cycle: it samples `word_valid_o`, `word_data_o` and `done_o` at every falling edge and takes a word only where valid and ready both held before the rising edge. Where valid was high and ready low at the previous falling edge, the bench checks that the same word is still present, so backpressure is verified on the exact cycle it applies.

// File: rtl/plane_scale_pkg.sv
`timescale 1ns/1ps
package plane_scale_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_TPZ  = 2'd1,
    MODE_PPF  = 2'd2
  } scl_mode_e;

  localparam int PPF_SCL_W = 17;
  localparam int TPZ_SCL_W = 21;
  localparam int RECIP_W   = 16;
  localparam logic [31:0] CTX_WORD = 32'hC0C0_C0C0;

  // descriptor slot order; emission order depends on it
  localparam int SLOT_SIZE     = 0;
  localparam int SLOT_LBUF     = 1;
  localparam int SLOT_HPPF     = 2;
  localparam int SLOT_VPPF     = 3;
  localparam int SLOT_VPPF_CTX = 4;
  localparam int SLOT_HTPZ0    = 5;
  localparam int SLOT_HTPZ1    = 6;
  localparam int SLOT_VTPZ0    = 7;
  localparam int SLOT_VTPZ1    = 8;
  localparam int SLOT_VTPZ_CTX = 9;
  localparam int SLOT_KERN0    = 10;
  localparam int NUM_KERN      = 4;
  localparam int NUM_SLOTS     = SLOT_KERN0 + NUM_KERN;

  function automatic logic [2:0] scl_code(scl_mode_e h, scl_mode_e v);
    logic [2:0] c;
    c = 3'd0;
    if      (h == MODE_PPF  && v == MODE_PPF ) c = 3'd0;
    else if (h == MODE_TPZ  && v == MODE_PPF ) c = 3'd1;
    else if (h == MODE_PPF  && v == MODE_TPZ ) c = 3'd2;
    else if (h == MODE_TPZ  && v == MODE_TPZ ) c = 3'd3;
    else if (h == MODE_PPF  && v == MODE_NONE) c = 3'd4;
    else if (h == MODE_NONE && v == MODE_PPF ) c = 3'd5;
    else if (h == MODE_NONE && v == MODE_TPZ ) c = 3'd6;
    else if (h == MODE_TPZ  && v == MODE_NONE) c = 3'd7;
    return c;
  endfunction

  // lowest set bit strictly above 'after'; -1 when none
  function automatic int pick_above(logic [15:0] m, int after);
    int r;
    r = -1;
    for (int i = 15; i >= 0; i--) begin
      if (m[i] && i > after) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/psg_axis_mode.sv
`timescale 1ns/1ps
module psg_axis_mode
  import plane_scale_pkg::*;
#(
  parameter int SRC_INT_W = 16,
  parameter int FRAC_W    = 16,
  parameter int DIM_W     = 12
) (
  input  logic [SRC_INT_W+FRAC_W-1:0] src_i,
  input  logic [DIM_W-1:0]            dst_i,
  output scl_mode_e                   mode_o,
  output logic [SRC_INT_W-1:0]        src_int_o,
  output logic                        frac_err_o,
  output logic                        zero_err_o
);

  logic [SRC_INT_W-1:0] dst_ext;

  assign src_int_o  = src_i[SRC_INT_W+FRAC_W-1:FRAC_W];
  assign frac_err_o = |src_i[FRAC_W-1:0];
  assign zero_err_o = (dst_i == '0);
  assign dst_ext    = SRC_INT_W'(dst_i);

  always_comb begin
    if (dst_ext > src_int_o)      mode_o = MODE_PPF;
    else if (dst_ext < src_int_o) mode_o = MODE_TPZ;
    else                          mode_o = MODE_NONE;
  end

endmodule

// File: rtl/psg_seq_div.sv
`timescale 1ns/1ps
module psg_seq_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [W:0]       shifted, diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign quo_o   = quo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        den_q  <= den_i;
        cnt_q  <= CNT_W'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/psg_word_seq.sv
`timescale 1ns/1ps
module psg_word_seq
  import plane_scale_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIM_W  = 12,
  parameter int KOFF_W = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 ready_i,
  input  scl_mode_e            h_mode_i,
  input  scl_mode_e            v_mode_i,
  input  logic [DIM_W-1:0]     dst_w_i,
  input  logic [DIM_W-1:0]     dst_h_i,
  input  logic [WORD_W-1:0]    lbuf_base_i,
  input  logic [KOFF_W-1:0]    kern_off_i,
  input  logic [TPZ_SCL_W-1:0] h_scale_i,
  input  logic [TPZ_SCL_W-1:0] v_scale_i,
  input  logic [RECIP_W-1:0]   h_recip_i,
  input  logic [RECIP_W-1:0]   v_recip_i,
  output logic                 valid_o,
  output logic [WORD_W-1:0]    data_o,
  output logic                 fin_o
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] mask;
  logic [SLOT_W-1:0]    slot_q;
  logic                 any_ppf, hs;
  int                   first_slot, next_slot;

  assign any_ppf = (h_mode_i == MODE_PPF) || (v_mode_i == MODE_PPF);

  always_comb begin
    mask                = '0;
    mask[SLOT_SIZE]     = 1'b1;
    mask[SLOT_LBUF]     = (v_mode_i != MODE_NONE);
    mask[SLOT_HPPF]     = (h_mode_i == MODE_PPF);
    mask[SLOT_VPPF]     = (v_mode_i == MODE_PPF);
    mask[SLOT_VPPF_CTX] = (v_mode_i == MODE_PPF);
    mask[SLOT_HTPZ0]    = (h_mode_i == MODE_TPZ);
    mask[SLOT_HTPZ1]    = (h_mode_i == MODE_TPZ);
    mask[SLOT_VTPZ0]    = (v_mode_i == MODE_TPZ);
    mask[SLOT_VTPZ1]    = (v_mode_i == MODE_TPZ);
    mask[SLOT_VTPZ_CTX] = (v_mode_i == MODE_TPZ);
    for (int k = 0; k < NUM_KERN; k++) mask[SLOT_KERN0+k] = any_ppf;
  end

  assign first_slot = pick_above(16'(mask), -1);
  assign next_slot  = pick_above(16'(mask), int'(slot_q));
  assign hs         = valid_o && ready_i;
  assign fin_o      = hs && (next_slot < 0);

  function automatic logic [WORD_W-1:0] ppf_word(logic [PPF_SCL_W-1:0] s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[30] = 1'b1;
    w[8 +: PPF_SCL_W] = s;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] tpz_word(logic [TPZ_SCL_W-1:0] s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[8 +: TPZ_SCL_W] = s;
    return w;
  endfunction

  always_comb begin
    data_o = '0;
    case (int'(slot_q))
      SLOT_SIZE: begin
        data_o[DIM_W-1:0]  = dst_w_i;
        data_o[16 +: DIM_W] = dst_h_i;
      end
      SLOT_LBUF:     data_o = lbuf_base_i;
      SLOT_HPPF:     data_o = ppf_word(h_scale_i[PPF_SCL_W-1:0]);
      SLOT_VPPF:     data_o = ppf_word(v_scale_i[PPF_SCL_W-1:0]);
      SLOT_VPPF_CTX: data_o = WORD_W'(CTX_WORD);
      SLOT_HTPZ0:    data_o = tpz_word(h_scale_i);
      SLOT_HTPZ1:    data_o = WORD_W'(h_recip_i);
      SLOT_VTPZ0:    data_o = tpz_word(v_scale_i);
      SLOT_VTPZ1:    data_o = WORD_W'(v_recip_i);
      SLOT_VTPZ_CTX: data_o = WORD_W'(CTX_WORD);
      default:       data_o = WORD_W'(kern_off_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      slot_q  <= '0;
    end else if (start_i) begin
      valid_o <= 1'b1;
      slot_q  <= SLOT_W'(first_slot);
    end else if (hs) begin
      if (next_slot >= 0) slot_q <= SLOT_W'(next_slot);
      else                valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/plane_scale_gen.sv
`timescale 1ns/1ps
module plane_scale_gen
  import plane_scale_pkg::*;
#(
  parameter int SRC_INT_W = 16,
  parameter int FRAC_W    = 16,
  parameter int DIM_W     = 12,
  parameter int KOFF_W    = 14,
  parameter int WORD_W    = SRC_INT_W + FRAC_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [SRC_INT_W+FRAC_W-1:0] src_w_i,
  input  logic [SRC_INT_W+FRAC_W-1:0] src_h_i,
  input  logic [FRAC_W-1:0]           src_x_frac_i,
  input  logic [FRAC_W-1:0]           src_y_frac_i,
  input  logic [DIM_W-1:0]            dst_w_i,
  input  logic [DIM_W-1:0]            dst_h_i,
  input  logic                        cursor_i,
  input  logic [WORD_W-1:0]           lbuf_base_i,
  input  logic [KOFF_W-1:0]           kern_off_i,
  output logic                        err_o,
  output logic [WORD_W-1:0]           ctl_o,
  output logic [WORD_W-1:0]           lbuf_size_o,
  output logic                        word_valid_o,
  input  logic                        word_ready_i,
  output logic [WORD_W-1:0]           word_data_o,
  output logic                        done_o
);

  localparam int LB_W    = SRC_INT_W + 5;
  localparam int NUM_OPS = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_GO, ST_WAIT, ST_EMIT, ST_FIN} st_e;

  // axis 0 = horizontal, axis 1 = vertical
  logic [SRC_INT_W+FRAC_W-1:0] ax_src [2];
  logic [DIM_W-1:0]            ax_dst [2];
  scl_mode_e                   ax_mode [2];
  logic [SRC_INT_W-1:0]        ax_int [2];
  logic [1:0]                  ax_frac, ax_zero;

  assign ax_src[0] = src_w_i;
  assign ax_src[1] = src_h_i;
  assign ax_dst[0] = dst_w_i;
  assign ax_dst[1] = dst_h_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    psg_axis_mode #(
      .SRC_INT_W(SRC_INT_W),
      .FRAC_W   (FRAC_W),
      .DIM_W    (DIM_W)
    ) u_mode (
      .src_i     (ax_src[a]),
      .dst_i     (ax_dst[a]),
      .mode_o    (ax_mode[a]),
      .src_int_o (ax_int[a]),
      .frac_err_o(ax_frac[a]),
      .zero_err_o(ax_zero[a])
    );
  end

  st_e                  st_q;
  logic                 accept, unity_now, err_now;
  logic [NUM_OPS-1:0]   need_now, need_q;
  logic [1:0]           op_q;
  int                   first_op, next_op;
  logic [SRC_INT_W-1:0] src_int_q [2];
  logic [DIM_W-1:0]     dst_q [2];
  scl_mode_e            mode_q [2];
  logic [WORD_W-1:0]    lbuf_base_q;
  logic [KOFF_W-1:0]    koff_q;
  logic [WORD_W-1:0]    scale_q [2];
  logic [RECIP_W-1:0]   recip_q [2];
  logic                 div_start, div_done;
  logic [WORD_W-1:0]    div_num, div_den, div_q;
  logic                 seq_start, seq_fin;
  logic [SRC_INT_W-1:0] pix;
  logic [LB_W-1:0]      lb_raw, lb_sum, lb_rnd;
  logic [2:0]           code_now;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign unity_now   = (ax_mode[0] == MODE_NONE) && (ax_mode[1] == MODE_NONE);
  assign err_now     = (|ax_frac) || (|src_x_frac_i) || (|src_y_frac_i) ||
                       (|ax_zero) || (cursor_i && !unity_now);
  assign code_now    = scl_code(ax_mode[0], ax_mode[1]);

  // op index: bit1 = axis, bit0 = reciprocal
  assign need_now = {ax_mode[1] == MODE_TPZ, ax_mode[1] != MODE_NONE,
                     ax_mode[0] == MODE_TPZ, ax_mode[0] != MODE_NONE};
  assign first_op = pick_above(16'(need_now), -1);
  assign next_op  = pick_above(16'(need_q), int'(op_q));

  // worst-case pixels per line
  assign pix    = (SRC_INT_W'(dst_w_i) > ax_int[0]) ? SRC_INT_W'(dst_w_i) : ax_int[0];
  assign lb_raw = (ax_mode[1] == MODE_TPZ) ? LB_W'({pix, 3'b000}) : LB_W'({pix, 4'b0000});
  assign lb_sum = lb_raw + LB_W'(31);
  assign lb_rnd = lb_sum & ~LB_W'(31);

  assign div_num   = op_q[0] ? '1 : {src_int_q[op_q[1]], FRAC_W'(0)};
  assign div_den   = op_q[0] ? scale_q[op_q[1]] : WORD_W'(dst_q[op_q[1]]);
  assign div_start = (st_q == ST_GO);
  assign seq_start = (st_q == ST_WAIT) && div_done && (next_op < 0);
  assign done_o    = (st_q == ST_FIN);

  psg_seq_div #(.W(WORD_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_q)
  );

  psg_word_seq #(
    .WORD_W(WORD_W),
    .DIM_W (DIM_W),
    .KOFF_W(KOFF_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (seq_start),
    .ready_i    (word_ready_i),
    .h_mode_i   (mode_q[0]),
    .v_mode_i   (mode_q[1]),
    .dst_w_i    (dst_q[0]),
    .dst_h_i    (dst_q[1]),
    .lbuf_base_i(lbuf_base_q),
    .kern_off_i (koff_q),
    .h_scale_i  (scale_q[0][TPZ_SCL_W-1:0]),
    .v_scale_i  (scale_q[1][TPZ_SCL_W-1:0]),
    .h_recip_i  (recip_q[0]),
    .v_recip_i  (recip_q[1]),
    .valid_o    (word_valid_o),
    .data_o     (word_data_o),
    .fin_o      (seq_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      err_o       <= 1'b0;
      ctl_o       <= '0;
      lbuf_size_o <= '0;
      need_q      <= '0;
      op_q        <= '0;
      lbuf_base_q <= '0;
      koff_q      <= '0;
      for (int a = 0; a < 2; a++) begin
        src_int_q[a] <= '0;
        dst_q[a]     <= '0;
        mode_q[a]    <= MODE_NONE;
        scale_q[a]   <= '0;
        recip_q[a]   <= '0;
      end
    end else begin
      err_o <= accept && err_now;
      case (st_q)
        ST_IDLE: begin
          if (accept && !err_now) begin
            for (int a = 0; a < 2; a++) begin
              src_int_q[a] <= ax_int[a];
              dst_q[a]     <= ax_dst[a];
              mode_q[a]    <= ax_mode[a];
            end
            lbuf_base_q <= lbuf_base_i;
            koff_q      <= kern_off_i;
            need_q      <= need_now;
            ctl_o       <= '0;
            ctl_o[4]    <= unity_now;
            ctl_o[7:5]  <= code_now;
            ctl_o[10:8] <= code_now;
            lbuf_size_o <= unity_now ? '0 : WORD_W'(lb_rnd);
            if (first_op < 0) begin
              st_q <= ST_FIN;
            end else begin
              op_q <= 2'(first_op);
              st_q <= ST_GO;
            end
          end
        end
        ST_GO: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            if (op_q[0]) recip_q[op_q[1]] <= div_q[RECIP_W-1:0];
            else         scale_q[op_q[1]] <= div_q;
            if (next_op >= 0) begin
              op_q <= 2'(next_op);
              st_q <= ST_GO;
            end else begin
              st_q <= ST_EMIT;
            end
          end
        end
        ST_EMIT: if (seq_fin) st_q <= ST_FIN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psg_checker.sv
`timescale 1ns/1ps
module psg_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              err_o,
  input logic [WORD_W-1:0] ctl_o,
  input logic [WORD_W-1:0] lbuf_size_o,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [WORD_W-1:0] word_data_o,
  input logic              done_o
);

  a_r12_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o));

  a_r6_lbuf_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbuf_size_o[4:0] == 5'd0);

  a_r6_unity_no_lbuf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[4] |-> lbuf_size_o == '0);

  a_r2_unity_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[4] |-> ctl_o[10:5] == 6'd0);

  a_r10_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !word_valid_o && req_ready_o);

  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !req_ready_o);

  a_r11_done_after_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !word_valid_o && !err_o);

endmodule

bind plane_scale_gen psg_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .err_o       (err_o),
  .ctl_o       (ctl_o),
  .lbuf_size_o (lbuf_size_o),
  .word_valid_o(word_valid_o),
  .word_ready_i(word_ready_i),
  .word_data_o (word_data_o),
  .done_o      (done_o)
);

// File: tb/plane_scale_gen_test.sv
`timescale 1ns/1ps
module plane_scale_gen_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] src_w_i = '0, src_h_i = '0;
  logic [15:0] src_x_frac_i = '0, src_y_frac_i = '0;
  logic [11:0] dst_w_i = '0, dst_h_i = '0;
  logic        cursor_i = 1'b0;
  logic [31:0] lbuf_base_i = '0;
  logic [13:0] kern_off_i = '0;
  logic        err_o;
  logic [31:0] ctl_o, lbuf_size_o;
  logic        word_valid_o;
  logic        word_ready_i = 1'b0;
  logic [31:0] word_data_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  plane_scale_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .src_w_i(src_w_i), .src_h_i(src_h_i), .src_x_frac_i(src_x_frac_i),
    .src_y_frac_i(src_y_frac_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
    .cursor_i(cursor_i), .lbuf_base_i(lbuf_base_i), .kern_off_i(kern_off_i),
    .err_o(err_o), .ctl_o(ctl_o), .lbuf_size_o(lbuf_size_o),
    .word_valid_o(word_valid_o), .word_ready_i(word_ready_i),
    .word_data_o(word_data_o), .done_o(done_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
    end
  endtask

  // bench mode codes: 0 none, 1 trapezoid, 2 polyphase
  function automatic int mode_of(int s, int d);
    if (d > s) return 2;
    if (d < s) return 1;
    return 0;
  endfunction

  function automatic logic [2:0] code_of(int h, int v);
    if (h == 2 && v == 2) return 3'd0;
    if (h == 1 && v == 2) return 3'd1;
    if (h == 2 && v == 1) return 3'd2;
    if (h == 1 && v == 1) return 3'd3;
    if (h == 2 && v == 0) return 3'd4;
    if (h == 0 && v == 2) return 3'd5;
    if (h == 0 && v == 1) return 3'd6;
    if (h == 1 && v == 0) return 3'd7;
    return 3'd0;
  endfunction

  task automatic run_case(input string nm, input int sw, input int sh, input int dw,
                          input int dh, input int wfr, input int hfr, input int xfr,
                          input int yfr, input bit cur, input logic [7:0] stall);
    int hm, vm, n_exp, n_got, pix, lb;
    bit err, unity, prev_stall, fin;
    logic [31:0] exp_w [16];
    string exp_t [16];
    logic [31:0] got_w [16];
    logic [31:0] prev_d, sc_h, sc_v, rc_h, rc_v, ctl_e;
    logic [31:0] base, koff;

    base = 32'h0001_2340 + 32'(sw);
    koff = 32'(14'h1ABC ^ 14'(dw));
    hm = mode_of(sw, dw);
    vm = mode_of(sh, dh);
    unity = (hm == 0 && vm == 0);
    err = (wfr != 0 || hfr != 0 || xfr != 0 || yfr != 0 || dw == 0 || dh == 0 ||
           (cur && !unity));
    sc_h = (dw != 0) ? 32'((longint'(sw) * 65536) / dw) : 32'd0;
    sc_v = (dh != 0) ? 32'((longint'(sh) * 65536) / dh) : 32'd0;
    rc_h = (sc_h != 0) ? 32'hFFFF_FFFF / sc_h : 32'd0;
    rc_v = (sc_v != 0) ? 32'hFFFF_FFFF / sc_v : 32'd0;
    ctl_e = 32'({code_of(hm, vm), code_of(hm, vm), unity, 4'b0});
    pix = (sw > dw) ? sw : dw;
    lb = unity ? 0 : (((pix * ((vm == 1) ? 8 : 16)) + 31) / 32) * 32;

    n_exp = 0;
    if (!err && !unity) begin
      exp_w[n_exp] = (32'(dh) << 16) | 32'(dw); exp_t[n_exp] = "R5"; n_exp++;
      if (vm != 0) begin exp_w[n_exp] = base; exp_t[n_exp] = "R5"; n_exp++; end
      if (hm == 2) begin
        exp_w[n_exp] = 32'h4000_0000 | ({15'b0, sc_h[16:0]} << 8); exp_t[n_exp] = "R3"; n_exp++;
      end
      if (vm == 2) begin
        exp_w[n_exp] = 32'h4000_0000 | ({15'b0, sc_v[16:0]} << 8); exp_t[n_exp] = "R3"; n_exp++;
        exp_w[n_exp] = 32'hC0C0_C0C0; exp_t[n_exp] = "R5"; n_exp++;
      end
      if (hm == 1) begin
        exp_w[n_exp] = {11'b0, sc_h[20:0]} << 8; exp_t[n_exp] = "R3"; n_exp++;
        exp_w[n_exp] = {16'b0, rc_h[15:0]}; exp_t[n_exp] = "R4"; n_exp++;
      end
      if (vm == 1) begin
        exp_w[n_exp] = {11'b0, sc_v[20:0]} << 8; exp_t[n_exp] = "R3"; n_exp++;
        exp_w[n_exp] = {16'b0, rc_v[15:0]}; exp_t[n_exp] = "R4"; n_exp++;
        exp_w[n_exp] = 32'hC0C0_C0C0; exp_t[n_exp] = "R5"; n_exp++;
      end
      if (hm == 2 || vm == 2) begin
        for (int k = 0; k < 4; k++) begin
          exp_w[n_exp] = koff; exp_t[n_exp] = "R5"; n_exp++;
        end
      end
    end

    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    src_w_i      = {sw[15:0], wfr[15:0]};
    src_h_i      = {sh[15:0], hfr[15:0]};
    src_x_frac_i = xfr[15:0];
    src_y_frac_i = yfr[15:0];
    dst_w_i      = dw[11:0];
    dst_h_i      = dh[11:0];
    cursor_i     = cur;
    lbuf_base_i  = base;
    kern_off_i   = koff[13:0];
    req_valid_i  = 1'b1;
    word_ready_i = stall[0];
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(err ? "R7 R8 R9" : "R8 R9", {nm, " err_o"}, 32'(err_o), 32'(err));
    if (err) begin
      for (int i = 0; i < 4; i++) begin
        chk("R10", {nm, " no word after reject"}, 32'(word_valid_o), 32'd0);
        chk("R10", {nm, " ready after reject"}, 32'(req_ready_o), 32'd1);
        @(negedge clk);
      end
      return;
    end
    chk("R2", {nm, " ctl_o"}, ctl_o, ctl_e);
    chk("R6", {nm, " lbuf_size_o"}, lbuf_size_o, 32'(lb));
    chk("R1", {nm, " h scaled bit"}, 32'(ctl_o[4]), 32'(unity));

    n_got = 0;
    prev_stall = 1'b0;
    prev_d = '0;
    fin = 1'b0;
    for (int t = 0; t < 2000 && !fin; t++) begin
      if (t > 0) begin
        @(negedge clk);
        word_ready_i = stall[t % 8];
      end
      #1;
      if (done_o) begin
        fin = 1'b1;
      end else begin
        if (word_valid_o) begin
          chk("R10", {nm, " not ready while busy"}, 32'(req_ready_o), 32'd0);
          if (prev_stall) chk("R12", {nm, " word held"}, word_data_o, prev_d);
          if (word_ready_i) begin
            if (n_got < 16) got_w[n_got] = word_data_o;
            n_got++;
          end
        end
        prev_stall = word_valid_o && !word_ready_i;
        prev_d = word_data_o;
      end
    end
    chk("R11", {nm, " done seen"}, 32'(fin), 32'd1);
    chk(unity ? "R10" : "R5", {nm, " word count"}, 32'(n_got), 32'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(exp_t[i], $sformatf("%s word %0d", nm, i), got_w[i], exp_w[i]);
    end
    @(negedge clk);
    chk("R11", {nm, " done one cycle"}, 32'(done_o), 32'd0);
    chk("R10", {nm, " idle after done"}, 32'(req_ready_o), 32'd1);
  endtask

  initial begin
    #12;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", "reset ready", 32'(req_ready_o), 32'd1);
    chk("R10", "reset err", 32'(err_o), 32'd0);
    chk("R12", "reset valid", 32'(word_valid_o), 32'd0);
    chk("R2", "reset ctl", ctl_o, 32'd0);
    chk("R11", "reset done", 32'(done_o), 32'd0);

    // R1 R2 mode pairs and codes
    run_case("unity",      100,   50,  100,  50, 0, 0, 0, 0, 1'b0, 8'hFF);
    run_case("ppf_ppf",    320,  240,  640, 480, 0, 0, 0, 0, 1'b0, 8'hFF);
    run_case("tpz_tpz",   1920, 1080,  640, 360, 0, 0, 0, 0, 1'b0, 8'hFF);
    run_case("ppf_tpz",    100,  200,  300,  50, 0, 0, 0, 0, 1'b0, 8'b1011_0010);
    run_case("tpz_ppf",    300,   50,  100, 200, 0, 0, 0, 0, 1'b0, 8'b0110_1101);
    run_case("ppf_none",   100,   50,  150,  50, 0, 0, 0, 0, 1'b0, 8'hFF);
    run_case("none_ppf",   100,   50,  100,  75, 0, 0, 0, 0, 1'b0, 8'b1100_1100);
    run_case("none_tpz",   100,   80,  100,  40, 0, 0, 0, 0, 1'b0, 8'hFF);
    run_case("tpz_none",   800,  600,  400, 600, 0, 0, 0, 0, 1'b0, 8'hFF);
    // R6 rounding, R3 R4 non-integer ratios
    run_case("round_lb",    33,   10,   20,   5, 0, 0, 0, 0, 1'b0, 8'b0101_0101);
    run_case("odd_ratio",    7,    3,    5,   2, 0, 0, 0, 0, 1'b0, 8'hFF);
    // R7 fractional rejects
    run_case("frac_x",     100,   50,  200, 100, 0, 0, 16'h8000, 0, 1'b0, 8'hFF);
    run_case("frac_y",     100,   50,  200, 100, 0, 0, 0, 16'h0001, 1'b0, 8'hFF);
    run_case("frac_h",     100,   50,  200, 100, 0, 16'h4000, 0, 0, 1'b0, 8'hFF);
    // R9 zero destination
    run_case("zero_w",     100,   50,    0, 100, 0, 0, 0, 0, 1'b0, 8'hFF);
    run_case("zero_h",     100,   50,  100,   0, 0, 0, 0, 0, 1'b0, 8'hFF);
    // R8 cursor planes
    run_case("cursor_scl",  64,   64,  128,  64, 0, 0, 0, 0, 1'b1, 8'hFF);
    run_case("cursor_one",  64,   64,   64,  64, 0, 0, 0, 0, 1'b1, 8'hFF);
    // recovery after rejects
    run_case("after_err",  640,  480,  320, 960, 0, 0, 0, 0, 1'b0, 8'b1001_0110);

    summary();
    $finish;
  end

endmodule